// File: doc/BRIEF.md
# Link Speed Step-Up Sequencer

This block runs the start-up procedure of a serial link controller that has to train at its lowest rate before it may try a faster one. After a start pulse, it limits the advertised top speed to Gen1 and enables the controller's training state machine. It then waits for the link to report up. Next it lifts the limit to Gen2 and asks the controller for a directed speed change. It waits until the controller clears that request bit, then confirms once more that the link is up. All register traffic toward the controller's configuration space uses read-modify-write, so fields that the sequencer does not own keep their values.

Every wait is bounded. A poll is an attempt, and attempts are spaced by a parameterised cycle counter. The sequence ends in one of two terminal states. In the done state it reports the negotiated speed read from the link status word. In the fail state it reports a failure. Both states hold until the next start pulse.

Top module: `link_speed_seq`

## Requirements
- R1: After synchronous reset, train_en_o, done_o, fail_o, cfg_req_o and speed_o are all 0. No configuration request is issued until start_i is seen.
- R2: A start first reads the capability register at CAP_ADDR. It then writes the value back with bits 3:0 replaced by 1 (Gen1) and all other bits unchanged.
- R3: train_en_o is 0 while the Gen1 write is acknowledged and is 1 from the next cycle on. It stays 1 until the next accepted start.
- R4: The link-up input is sampled once per attempt, with POLL_CYC+1 cycles between attempts. After MAX_POLLS low samples the sequence fails, so fail_o rises exactly MAX_POLLS + (MAX_POLLS-1)*POLL_CYC cycles after train_en_o rises. A high sample on the last allowed attempt still succeeds.
- R5: Once the link is up, the capability register is read and written back with bits 3:0 set to 2 (Gen2). The control register at CTL_ADDR is then read and written back with bit 17 set and all other bits unchanged.
- R6: After that write, the control register is re-read until bit 17 reads 0. If MAX_POLLS reads in a row return bit 17 set, the sequence fails with no further transfers.
- R7: After the speed change completes, link-up is polled again under the same rules as R4. If that wait fails, the sequence ends in fail without reading the status register.
- R8: On success the status register at STA_ADDR is read once. speed_o then takes its bits 19:16 and done_o rises. done_o and fail_o are never 1 together. In the done state, speed_o and done_o hold until the next start.
- R9: start_i is accepted only in the idle, done or fail states. An accepted start clears done_o, fail_o, speed_o and train_en_o on the next cycle. A start while the sequence runs has no effect on the transfers or the outcome.
- R10: Once cfg_req_o is raised, it stays high with address, write flag and write data unchanged until cfg_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a bring-up sequence |
| cfg_req_o | output | 1 | Configuration transfer request, held until acknowledged |
| cfg_we_o | output | 1 | 1 for a write, 0 for a read |
| cfg_addr_o | output | ADDR_W | Configuration register address |
| cfg_wdata_o | output | 32 | Write data |
| cfg_rdata_i | input | 32 | Read data, valid with cfg_ack_i |
| cfg_ack_i | input | 1 | One-cycle completion of the current transfer |
| link_up_i | input | 1 | Link reported up by the training state machine |
| train_en_o | output | 1 | Enable for the training state machine |
| done_o | output | 1 | Sequence ended successfully |
| fail_o | output | 1 | Sequence ended with a timeout |
| speed_o | output | 4 | Negotiated speed code from the status word |

## Verification
The sequence is driven against a modelled configuration space and training machine while the following are varied: the preset register contents, the link-up latency, the speed-change latency, the partner's final speed, and whether the link returns after the change. Presets with an old speed field of 7 or 2, and with every other bit set or clear, separate a true read-modify-write from a write of a constant. A link latency that lands exactly on the last allowed attempt, and one a cycle later, pin the R4 bound and its timing to the cycle. A speed-change bit that never clears, and a link that drops after the change, show which wait produced the failure and that no status read follows it. A start pulse in the middle of a run must leave the transfer order intact.

// File: rtl/lss_pkg.sv
package lss_pkg;

    localparam int WORD_W  = 32;
    localparam int SPD_W   = 4;
    localparam int CHG_BIT = 17;
    localparam int NEG_LSB = 16;

    localparam logic [SPD_W-1:0] GEN1 = 4'd1;
    localparam logic [SPD_W-1:0] GEN2 = 4'd2;

    typedef enum logic [1:0] {
        SEL_CAP,
        SEL_CTL,
        SEL_STA
    } reg_sel_t;

    typedef struct packed {
        logic     req;
        logic     we;
        reg_sel_t sel;
    } cfg_cmd_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CAP_RD1,
        S_CAP_WR1,
        S_LNK1_CHK,
        S_LNK1_GAP,
        S_CAP_RD2,
        S_CAP_WR2,
        S_CTL_RD,
        S_CTL_WR,
        S_SPD_RD,
        S_SPD_GAP,
        S_LNK2_CHK,
        S_LNK2_GAP,
        S_STA_RD,
        S_DONE,
        S_FAIL
    } seq_state_t;

    function automatic logic [WORD_W-1:0] with_speed(input logic [WORD_W-1:0] w,
                                                     input logic [SPD_W-1:0]  g);
        return {w[WORD_W-1:SPD_W], g};
    endfunction

    function automatic logic [WORD_W-1:0] with_change(input logic [WORD_W-1:0] w);
        return w | (WORD_W'(1) << CHG_BIT);
    endfunction

    function automatic logic [SPD_W-1:0] neg_speed(input logic [WORD_W-1:0] w);
        return w[NEG_LSB +: SPD_W];
    endfunction

endpackage

// File: rtl/lss_pacer.sv
module lss_pacer #(
    parameter int GAP_CYC   = 12500,
    parameter int MAX_TRIES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic miss_i,
    input  logic arm_i,
    output logic due_o,
    output logic last_o
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int TW = $clog2(MAX_TRIES + 1);

    logic [GW-1:0] gap_q;
    logic [TW-1:0] tries_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (arm_i) begin
            gap_q <= GW'(GAP_CYC - 1);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - GW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            tries_q <= '0;
        end else if (miss_i) begin
            tries_q <= tries_q + TW'(1);
        end
    end

    assign due_o  = (gap_q == '0);
    assign last_o = (tries_q == TW'(MAX_TRIES - 1));

endmodule

// File: rtl/lss_fsm.sv
module lss_fsm
    import lss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              link_up_i,
    input  logic              ack_i,
    input  logic [WORD_W-1:0] rdata_i,
    input  logic              due_i,
    input  logic              last_i,
    output cfg_cmd_t          cmd_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic              clr_o,
    output logic              miss_o,
    output logic              arm_o,
    output logic              train_en_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [SPD_W-1:0]  speed_o
);
    seq_state_t        st_q;
    logic [WORD_W-1:0] hold_q;
    logic              chg_busy;
    logic              lnk_chk;

    assign chg_busy = rdata_i[CHG_BIT];
    assign lnk_chk  = (st_q == S_LNK1_CHK) || (st_q == S_LNK2_CHK);

    always_comb begin
        cmd_o   = '{req: 1'b0, we: 1'b0, sel: SEL_CAP};
        wdata_o = hold_q;
        case (st_q)
            S_CAP_RD1, S_CAP_RD2: cmd_o = '{req: 1'b1, we: 1'b0, sel: SEL_CAP};
            S_CAP_WR1: begin
                cmd_o   = '{req: 1'b1, we: 1'b1, sel: SEL_CAP};
                wdata_o = with_speed(hold_q, GEN1);
            end
            S_CAP_WR2: begin
                cmd_o   = '{req: 1'b1, we: 1'b1, sel: SEL_CAP};
                wdata_o = with_speed(hold_q, GEN2);
            end
            S_CTL_RD, S_SPD_RD: cmd_o = '{req: 1'b1, we: 1'b0, sel: SEL_CTL};
            S_CTL_WR: begin
                cmd_o   = '{req: 1'b1, we: 1'b1, sel: SEL_CTL};
                wdata_o = with_change(hold_q);
            end
            S_STA_RD: cmd_o = '{req: 1'b1, we: 1'b0, sel: SEL_STA};
            default: ;
        endcase
    end

    assign miss_o = (lnk_chk && !link_up_i) || ((st_q == S_SPD_RD) && ack_i && chg_busy);
    assign arm_o  = miss_o && !last_i;
    assign clr_o  = ack_i && ((st_q == S_CAP_WR1) || (st_q == S_CTL_WR) ||
                              ((st_q == S_SPD_RD) && !chg_busy));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            hold_q     <= '0;
            train_en_o <= 1'b0;
            done_o     <= 1'b0;
            fail_o     <= 1'b0;
            speed_o    <= '0;
        end else begin
            case (st_q)
                S_IDLE, S_DONE, S_FAIL: if (start_i) begin
                    st_q       <= S_CAP_RD1;
                    train_en_o <= 1'b0;
                    done_o     <= 1'b0;
                    fail_o     <= 1'b0;
                    speed_o    <= '0;
                end
                S_CAP_RD1: if (ack_i) begin
                    hold_q <= rdata_i;
                    st_q   <= S_CAP_WR1;
                end
                S_CAP_WR1: if (ack_i) begin
                    train_en_o <= 1'b1;
                    st_q       <= S_LNK1_CHK;
                end
                S_LNK1_CHK: begin
                    if (link_up_i)   st_q <= S_CAP_RD2;
                    else if (last_i) begin st_q <= S_FAIL; fail_o <= 1'b1; end
                    else             st_q <= S_LNK1_GAP;
                end
                S_LNK1_GAP: if (due_i) st_q <= S_LNK1_CHK;
                S_CAP_RD2: if (ack_i) begin
                    hold_q <= rdata_i;
                    st_q   <= S_CAP_WR2;
                end
                S_CAP_WR2: if (ack_i) st_q <= S_CTL_RD;
                S_CTL_RD: if (ack_i) begin
                    hold_q <= rdata_i;
                    st_q   <= S_CTL_WR;
                end
                S_CTL_WR: if (ack_i) st_q <= S_SPD_RD;
                S_SPD_RD: if (ack_i) begin
                    if (!chg_busy)   st_q <= S_LNK2_CHK;
                    else if (last_i) begin st_q <= S_FAIL; fail_o <= 1'b1; end
                    else             st_q <= S_SPD_GAP;
                end
                S_SPD_GAP: if (due_i) st_q <= S_SPD_RD;
                S_LNK2_CHK: begin
                    if (link_up_i)   st_q <= S_STA_RD;
                    else if (last_i) begin st_q <= S_FAIL; fail_o <= 1'b1; end
                    else             st_q <= S_LNK2_GAP;
                end
                S_LNK2_GAP: if (due_i) st_q <= S_LNK2_CHK;
                S_STA_RD: if (ack_i) begin
                    speed_o <= neg_speed(rdata_i);
                    done_o  <= 1'b1;
                    st_q    <= S_DONE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
    import lss_pkg::*;
#(
    parameter int               ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CAP_ADDR = 12'h07C,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h80C,
    parameter logic [ADDR_W-1:0] STA_ADDR = 12'h080,
    parameter int               POLL_CYC  = 12500,
    parameter int               MAX_POLLS = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              cfg_req_o,
    output logic              cfg_we_o,
    output logic [ADDR_W-1:0] cfg_addr_o,
    output logic [31:0]       cfg_wdata_o,
    input  logic [31:0]       cfg_rdata_i,
    input  logic              cfg_ack_i,
    input  logic              link_up_i,
    output logic              train_en_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [3:0]        speed_o
);
    cfg_cmd_t cmd;
    logic     clr, miss, arm, due, last;

    lss_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .link_up_i  (link_up_i),
        .ack_i      (cfg_ack_i),
        .rdata_i    (cfg_rdata_i),
        .due_i      (due),
        .last_i     (last),
        .cmd_o      (cmd),
        .wdata_o    (cfg_wdata_o),
        .clr_o      (clr),
        .miss_o     (miss),
        .arm_o      (arm),
        .train_en_o (train_en_o),
        .done_o     (done_o),
        .fail_o     (fail_o),
        .speed_o    (speed_o)
    );

    lss_pacer #(
        .GAP_CYC   (POLL_CYC),
        .MAX_TRIES (MAX_POLLS)
    ) u_pacer (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .miss_i (miss),
        .arm_i  (arm),
        .due_o  (due),
        .last_o (last)
    );

    assign cfg_req_o = cmd.req;
    assign cfg_we_o  = cmd.we;

    always_comb begin
        case (cmd.sel)
            SEL_CAP: cfg_addr_o = CAP_ADDR;
            SEL_CTL: cfg_addr_o = CTL_ADDR;
            default: cfg_addr_o = STA_ADDR;
        endcase
    end

endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
    parameter int               ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CAP_ADDR = 12'h07C,
    parameter logic [ADDR_W-1:0] STA_ADDR = 12'h080
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              cfg_req_o,
    input logic              cfg_we_o,
    input logic [ADDR_W-1:0] cfg_addr_o,
    input logic [31:0]       cfg_wdata_o,
    input logic              cfg_ack_i,
    input logic              train_en_o,
    input logic              done_o,
    input logic              fail_o,
    input logic [3:0]        speed_o
);
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        cfg_req_o && !cfg_ack_i |=> cfg_req_o && $stable(cfg_we_o) &&
        $stable(cfg_addr_o) && $stable(cfg_wdata_o)); // R10

    AST_TRAIN_AFTER_GEN1: assert property (@(posedge clk) disable iff (rst)
        $rose(train_en_o) |-> $past(cfg_ack_i && cfg_we_o && cfg_addr_o == CAP_ADDR &&
        cfg_wdata_o[3:0] == 4'd1)); // R3

    AST_TRAIN_HELD: assert property (@(posedge clk) disable iff (rst)
        train_en_o && !start_i |=> train_en_o); // R3

    AST_DONE_AFTER_STATUS: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(cfg_ack_i && !cfg_we_o && cfg_addr_o == STA_ADDR)); // R8

    AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_o && fail_o)); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        done_o && !start_i |=> done_o && $stable(speed_o)); // R8

    AST_END_QUIET: assert property (@(posedge clk) disable iff (rst)
        (done_o || fail_o) |-> !cfg_req_o); // R7

endmodule

bind link_speed_seq lss_checker #(
    .ADDR_W   (ADDR_W),
    .CAP_ADDR (CAP_ADDR),
    .STA_ADDR (STA_ADDR)
) u_lss_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .cfg_req_o   (cfg_req_o),
    .cfg_we_o    (cfg_we_o),
    .cfg_addr_o  (cfg_addr_o),
    .cfg_wdata_o (cfg_wdata_o),
    .cfg_ack_i   (cfg_ack_i),
    .train_en_o  (train_en_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .speed_o     (speed_o)
);

// File: tb/link_speed_seq_test.sv
module link_speed_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 4;
    localparam int M  = 8;
    localparam int AW = 12;
    localparam logic [AW-1:0] CAPA = 12'h07C;
    localparam logic [AW-1:0] CTLA = 12'h80C;
    localparam logic [AW-1:0] STAA = 12'h080;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic cfg_req, cfg_we, cfg_ack = 1'b0, link_up = 1'b0;
    logic [AW-1:0] cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata = '0;
    logic train_en, done, fail;
    logic [3:0] speed;

    int n_checks = 0, n_errors = 0;

    link_speed_seq #(.ADDR_W(AW), .CAP_ADDR(CAPA), .CTL_ADDR(CTLA), .STA_ADDR(STAA),
                     .POLL_CYC(P), .MAX_POLLS(M)) uut (
        .clk(clk), .rst(rst), .start_i(start), .cfg_req_o(cfg_req), .cfg_we_o(cfg_we),
        .cfg_addr_o(cfg_addr), .cfg_wdata_o(cfg_wdata), .cfg_rdata_i(cfg_rdata),
        .cfg_ack_i(cfg_ack), .link_up_i(link_up), .train_en_o(train_en),
        .done_o(done), .fail_o(fail), .speed_o(speed));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // configuration space and training model
    int link_lat = 1000000, chg_lat = 1;
    logic [3:0] neg_gen = 4'd2;
    bit relink = 1'b1;
    logic reload = 1'b0;
    logic [31:0] pre_cap = '0, pre_ctl = '0, pre_sta = '0;
    logic [31:0] cap_r = '0, ctl_r = '0, sta_r = '0;
    int tcnt = 0, ccnt = 0;
    bit changed = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            cfg_ack <= 1'b0;
            link_up <= 1'b0;
            tcnt    <= 0;
            ccnt    <= 0;
        end else begin
            if (reload) begin
                cap_r <= pre_cap; ctl_r <= pre_ctl; sta_r <= pre_sta; changed <= 1'b0;
            end
            if (ctl_r[17]) begin
                if (ccnt + 1 >= chg_lat) begin
                    ctl_r[17]    <= 1'b0;
                    sta_r[19:16] <= neg_gen;
                    changed      <= 1'b1;
                    ccnt         <= 0;
                end else ccnt <= ccnt + 1;
            end
            cfg_ack <= 1'b0;
            if (cfg_req && !cfg_ack) begin
                cfg_ack <= 1'b1;
                if (cfg_addr == CAPA) cfg_rdata <= cap_r;
                else if (cfg_addr == CTLA) cfg_rdata <= ctl_r;
                else cfg_rdata <= sta_r;
                if (cfg_we) begin
                    if (cfg_addr == CAPA) cap_r <= cfg_wdata;
                    else if (cfg_addr == CTLA) ctl_r <= cfg_wdata;
                end
            end
            if (!train_en) begin
                tcnt <= 0; link_up <= 1'b0;
            end else begin
                tcnt    <= tcnt + 1;
                link_up <= (tcnt + 1 >= link_lat) && (relink || !changed);
            end
        end
    end

    // scoreboard
    typedef struct packed { logic we; logic [AW-1:0] addr; logic [31:0] data; } tx_t;
    tx_t exp_q[$];
    string cur_req = "R2";
    bit last_rd = 1'b0, after_ctl_wr = 1'b0, pend = 1'b0, gen1_seen = 1'b0;
    logic [AW-1:0] last_rd_addr = '0;
    logic [44:0] snap = '0;
    int ctl_polls = 0;

    task automatic push_tx(input logic we, input logic [AW-1:0] a, input logic [31:0] d);
        tx_t t;
        t.we = we; t.addr = a; t.data = d;
        exp_q.push_back(t);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (pend) begin
                chk("R10", "request held", 64'({cfg_req, cfg_we, cfg_addr, cfg_wdata}),
                    64'({1'b1, snap}));
                pend = 1'b0;
            end
            if (gen1_seen) begin
                chk("R3", "enable after Gen1 write", 64'(train_en), 64'd1);
                gen1_seen = 1'b0;
            end
            if (cfg_req && !cfg_ack) begin
                pend = 1'b1;
                snap = {cfg_we, cfg_addr, cfg_wdata};
            end
            if (cfg_req && cfg_ack) begin
                if (!cfg_we && cfg_addr == CTLA && after_ctl_wr) ctl_polls++;
                if (!(!cfg_we && last_rd && cfg_addr == last_rd_addr)) begin
                    if (exp_q.size() == 0) begin
                        chk(cur_req, "unexpected transfer",
                            64'({1'b1, cfg_we, cfg_addr, cfg_wdata}), 64'd0);
                    end else begin
                        tx_t t;
                        t = exp_q.pop_front();
                        if (t.we)
                            chk(cur_req, "write transfer", 64'({cfg_we, cfg_addr, cfg_wdata}),
                                64'(t));
                        else
                            chk(cur_req, "read transfer", 64'({cfg_we, cfg_addr}),
                                64'({t.we, t.addr}));
                    end
                end
                if (cfg_we && cfg_addr == CTLA) begin after_ctl_wr = 1'b1; ctl_polls = 0; end
                if (cfg_we && cfg_addr == CAPA && cfg_wdata[3:0] == 4'd1) begin
                    chk("R3", "enable low before Gen1 ack", 64'(train_en), 64'd0);
                    gen1_seen = 1'b1;
                end
                last_rd = !cfg_we;
                last_rd_addr = cfg_addr;
            end
        end
    end

    // outcome: 0 done, 1 link-1 fail, 2 speed-change fail, 3 link-2 fail
    task automatic run_seq(input string tag, input logic [31:0] c, input logic [31:0] t,
                           input logic [31:0] s, input int ll, input int cl,
                           input logic [3:0] g, input bit rl, input int outcome,
                           input bit poke, output int en_cycles);
        pre_cap = c; pre_ctl = t; pre_sta = s;
        link_lat = ll; chg_lat = cl; neg_gen = g; relink = rl;
        cur_req = tag; after_ctl_wr = 1'b0; ctl_polls = 0; last_rd = 1'b0;
        push_tx(1'b0, CAPA, '0);
        push_tx(1'b1, CAPA, {c[31:4], 4'd1});
        if (outcome != 1) begin
            push_tx(1'b0, CAPA, '0);
            push_tx(1'b1, CAPA, {c[31:4], 4'd2});
            push_tx(1'b0, CTLA, '0);
            push_tx(1'b1, CTLA, t | 32'h0002_0000);
            push_tx(1'b0, CTLA, '0);
            if (outcome == 0) push_tx(1'b0, STAA, '0);
        end
        @(negedge clk); start = 1'b1; reload = 1'b1;
        @(negedge clk); start = 1'b0; reload = 1'b0;
        chk("R9", "start clears results",
            64'({done, fail, train_en, speed}), 64'd0);
        en_cycles = 0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (done || fail) break;
            if (train_en) en_cycles++;
            if (poke) start = (en_cycles == 3);
        end
        start = 1'b0;
        chk(tag, "done flag", 64'(done), 64'(outcome == 0));
        chk(tag, "fail flag", 64'(fail), 64'(outcome != 0));
        chk(tag, "speed", 64'(speed), (outcome == 0) ? 64'(s[19:16] & 4'h0 | g) : 64'd0);
        chk(tag, "all expected transfers seen", 64'(exp_q.size()), 64'd0);
        exp_q.delete();
        repeat (3) @(negedge clk);
        chk(tag, "no transfer after end", 64'(cfg_req), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int en;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset outputs", 64'({train_en, done, fail, cfg_req, speed}), 64'd0);
        repeat (6) @(negedge clk);
        chk("R1", "idle without start", 64'(cfg_req), 64'd0);

        // R2 R5 R6 R8: normal bring-up with mixed preset bits
        run_seq("R5", 32'hABCD_1237, 32'h0000_00C5, 32'h5550_0041, 10, 6, 4'd2, 1'b1, 0, 1'b0, en);
        chk("R6", "speed-change poll count in range", 64'(ctl_polls >= 1 && ctl_polls <= M), 64'd1);
        chk("R3", "enable held after done", 64'(train_en), 64'd1);
        chk("R8", "result held", 64'({done, speed}), 64'({1'b1, 4'd2}));

        // R2: old field 2 and all other bits set; partner stays at Gen1
        run_seq("R2", 32'hFFFF_FFF2, 32'hFFFD_FFFF, 32'h000F_0000, 1, 1, 4'd1, 1'b1, 0, 1'b0, en);

        // R4: link up on the last allowed attempt
        run_seq("R4", 32'h0000_0010, 32'h0, 32'h0, 35, 2, 4'd2, 1'b1, 0, 1'b0, en);

        // R4: link up one cycle too late
        run_seq("R4", 32'h1234_5670, 32'h0, 32'h0, 36, 2, 4'd2, 1'b1, 1, 1'b0, en);
        chk("R4", "cycles from enable to fail", 64'(en), 64'(M + (M - 1) * P));
        chk("R3", "enable held after fail", 64'(train_en), 64'd1);

        // R6: speed-change bit never clears
        run_seq("R6", 32'h0, 32'h0000_8001, 32'h0, 3, 100000, 4'd2, 1'b1, 2, 1'b0, en);
        chk("R6", "control reads after change request", 64'(ctl_polls), 64'(M));

        // R7: link lost after the speed change
        run_seq("R7", 32'h0, 32'h0, 32'h0, 3, 3, 4'd2, 1'b0, 3, 1'b0, en);

        // R9: start pulse in the middle of a run
        run_seq("R9", 32'h0F0F_0F03, 32'h00F0_0000, 32'h0, 12, 4, 4'd2, 1'b1, 0, 1'b1, en);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule